// File: doc/BRIEF.md
# Compact Instruction Decoder

This block turns one 16-bit instruction word of a small three-format instruction set (eight general registers, 4-bit major opcode) into everything the rest of a processor datapath needs: the three register indices, a 16-bit extended immediate, the raw 7-bit jump address, and a set of control signals for the ALU, register file, data memory and program-counter logic. It is purely combinational, so its outputs follow the instruction word within the same cycle.

The register file, ALU, memory and PC sequencer sit outside and consume the decode results. Instructions that are not part of the set raise an illegal flag and leave every control output inactive, so that an undefined word can never change architectural state.

Top module: `cdec_top`

## Requirements
- R1: For every word, rs_idx = instr[11:9], rt_idx = instr[8:6], rd_idx = instr[5:3] and jmp_field = instr[6:0].
- R2: Opcode 0000 with funct (instr[2:0]) 000, 001, 010, 011, 100, 101 gives alu_op 0 (add), 1 (subtract), 2 (and), 3 (or), 4 (multiply), 5 (xor), with reg_we = 1, wr_idx = rd_idx and alu_src_imm = 0.
- R3: is_mult is 1 exactly for opcode 0000 with funct 100.
- R4: Opcode 0000 with funct 111 sets jump_reg = 1 and writes no register.
- R5: Opcodes 0010, 0011, 0100, 0101 give alu_op 0, 1, 2, 3 respectively, with reg_we = 1, wr_idx = rt_idx and alu_src_imm = 1.
- R6: Opcodes 0010, 0011, 0110, 0111, 1000, 1001 present instr[5:0] sign-extended to 16 bits on imm_ext.
- R7: Opcodes 0100 and 0101 present instr[5:0] zero-extended on imm_ext; for opcodes 0000, 1110, 1111 and illegal words imm_ext is 0.
- R8: Opcode 0111 (load) sets mem_rd = 1, mem_to_reg = 1, reg_we = 1, wr_idx = rt_idx, alu_op 0, alu_src_imm = 1.
- R9: Opcode 0110 (store) sets mem_wr = 1, alu_op 0, alu_src_imm = 1 and reg_we = 0.
- R10: Opcode 1000 sets br_eq = 1 and opcode 1001 sets br_ne = 1; both use alu_op 1 with alu_src_imm = 0 and write nothing.
- R11: Opcode 1110 sets jump = 1 only; opcode 1111 sets jump = 1, link = 1, reg_we = 1 and wr_idx = 7.
- R12: Funct 110 under opcode 0000, and opcodes 0001, 1010, 1011, 1100, 1101, set illegal = 1 with every other control output 0, alu_op 0 and wr_idx 0.
- R13: Whenever reg_we = 0, wr_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word to decode |
| rs_idx | output | 3 | First source register index |
| rt_idx | output | 3 | Second source / immediate-format destination index |
| rd_idx | output | 3 | Register-format destination index |
| imm_ext | output | 16 | Extended immediate |
| jmp_field | output | 7 | Raw jump address field |
| alu_op | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 mul, 5 xor |
| reg_we | output | 1 | Register file write enable |
| wr_idx | output | 3 | Register index to write |
| alu_src_imm | output | 1 | ALU second operand is imm_ext |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| mem_to_reg | output | 1 | Write-back data comes from memory |
| br_eq | output | 1 | Branch if equal |
| br_ne | output | 1 | Branch if not equal |
| jump | output | 1 | Absolute jump to address field |
| jump_reg | output | 1 | Jump to the value of rs |
| link | output | 1 | Write-back data is the return address |
| is_mult | output | 1 | Multiply instruction |
| illegal | output | 1 | Word is not a defined instruction |

## Verification
The assertions watch the cross-signal invariants that hold for any word: an illegal word never writes, a link always targets register 7, at most one PC-changing control is active, a store never writes back, loads always pair memory read with write-back, the write index is cleared when nothing is written, and the immediate extension matches the opcode's signedness. The exact opcode-to-operation mapping, the field positions and the funct decoding can only be shown by the bench, which sweeps every one of the 65536 words against an independent model and adds directed boundary words such as the most negative immediate.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

    localparam int INSTR_W = 16;
    localparam int OPC_W   = 4;
    localparam int REG_W   = 3;
    localparam int FUNCT_W = 3;
    localparam int IMM_W   = 6;
    localparam int JADDR_W = 7;
    localparam int ALUOP_W = 3;

    localparam logic [REG_W-1:0] LINK_REG = REG_W'(7);

    // major opcodes
    localparam logic [OPC_W-1:0] OPC_RFMT = 4'h0;
    localparam logic [OPC_W-1:0] OPC_ADDI = 4'h2;
    localparam logic [OPC_W-1:0] OPC_SUBI = 4'h3;
    localparam logic [OPC_W-1:0] OPC_ANDI = 4'h4;
    localparam logic [OPC_W-1:0] OPC_ORI  = 4'h5;
    localparam logic [OPC_W-1:0] OPC_STB  = 4'h6;
    localparam logic [OPC_W-1:0] OPC_LDB  = 4'h7;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 4'h8;
    localparam logic [OPC_W-1:0] OPC_BNE  = 4'h9;
    localparam logic [OPC_W-1:0] OPC_JMP  = 4'hE;
    localparam logic [OPC_W-1:0] OPC_JAL  = 4'hF;

    // register-format function codes
    localparam logic [FUNCT_W-1:0] FN_ADD = 3'd0;
    localparam logic [FUNCT_W-1:0] FN_SUB = 3'd1;
    localparam logic [FUNCT_W-1:0] FN_AND = 3'd2;
    localparam logic [FUNCT_W-1:0] FN_OR  = 3'd3;
    localparam logic [FUNCT_W-1:0] FN_MUL = 3'd4;
    localparam logic [FUNCT_W-1:0] FN_XOR = 3'd5;
    localparam logic [FUNCT_W-1:0] FN_JR  = 3'd7;

    typedef enum logic [ALUOP_W-1:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_MUL = 3'd4,
        ALU_XOR = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_NONE = 2'd0,
        EXT_SIGN = 2'd1,
        EXT_ZERO = 2'd2
    } ext_kind_e;

    typedef enum logic [1:0] {
        WSEL_NONE = 2'd0,
        WSEL_RD   = 2'd1,
        WSEL_RT   = 2'd2,
        WSEL_LINK = 2'd3
    } wsel_e;

    typedef struct packed {
        logic [OPC_W-1:0]   opc;
        logic [REG_W-1:0]   rs;
        logic [REG_W-1:0]   rt;
        logic [REG_W-1:0]   rd;
        logic [FUNCT_W-1:0] funct;
        logic [IMM_W-1:0]   imm;
        logic [JADDR_W-1:0] jaddr;
    } fields_t;

    typedef struct packed {
        alu_op_e   alu_op;
        wsel_e     wsel;
        ext_kind_e ext;
        logic      alu_src_imm;
        logic      mem_rd;
        logic      mem_wr;
        logic      mem_to_reg;
        logic      br_eq;
        logic      br_ne;
        logic      jump;
        logic      jump_reg;
        logic      link;
        logic      is_mult;
        logic      illegal;
    } ctrl_t;

    localparam ctrl_t CTRL_QUIET = '{
        alu_op:      ALU_ADD,
        wsel:        WSEL_NONE,
        ext:         EXT_NONE,
        alu_src_imm: 1'b0,
        mem_rd:      1'b0,
        mem_wr:      1'b0,
        mem_to_reg:  1'b0,
        br_eq:       1'b0,
        br_ne:       1'b0,
        jump:        1'b0,
        jump_reg:    1'b0,
        link:        1'b0,
        is_mult:     1'b0,
        illegal:     1'b0
    };

    function automatic fields_t split_word(input logic [INSTR_W-1:0] w);
        fields_t f;
        f.opc   = w[INSTR_W-1 -: OPC_W];
        f.rs    = w[INSTR_W-OPC_W-1 -: REG_W];
        f.rt    = w[INSTR_W-OPC_W-REG_W-1 -: REG_W];
        f.rd    = w[INSTR_W-OPC_W-2*REG_W-1 -: REG_W];
        f.funct = w[FUNCT_W-1:0];
        f.imm   = w[IMM_W-1:0];
        f.jaddr = w[JADDR_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/cdec_ctrl.sv
module cdec_ctrl
    import cdec_pkg::*;
(
    input  logic [OPC_W-1:0]   opc,
    input  logic [FUNCT_W-1:0] funct,
    output ctrl_t              ctrl
);

    ctrl_t rfmt;

    // register-format sub-decode on the function code
    always_comb begin
        rfmt = CTRL_QUIET;
        case (funct)
            FN_ADD: begin rfmt.alu_op = ALU_ADD; rfmt.wsel = WSEL_RD; end
            FN_SUB: begin rfmt.alu_op = ALU_SUB; rfmt.wsel = WSEL_RD; end
            FN_AND: begin rfmt.alu_op = ALU_AND; rfmt.wsel = WSEL_RD; end
            FN_OR:  begin rfmt.alu_op = ALU_OR;  rfmt.wsel = WSEL_RD; end
            FN_MUL: begin
                rfmt.alu_op  = ALU_MUL;
                rfmt.wsel    = WSEL_RD;
                rfmt.is_mult = 1'b1;
            end
            FN_XOR: begin rfmt.alu_op = ALU_XOR; rfmt.wsel = WSEL_RD; end
            FN_JR:  rfmt.jump_reg = 1'b1;
            default: rfmt.illegal = 1'b1;
        endcase
    end

    // major opcode decode
    always_comb begin
        ctrl = CTRL_QUIET;
        case (opc)
            OPC_RFMT: ctrl = rfmt;
            OPC_ADDI, OPC_SUBI, OPC_ANDI, OPC_ORI: begin
                ctrl.wsel        = WSEL_RT;
                ctrl.alu_src_imm = 1'b1;
                case (opc)
                    OPC_ADDI: begin ctrl.alu_op = ALU_ADD; ctrl.ext = EXT_SIGN; end
                    OPC_SUBI: begin ctrl.alu_op = ALU_SUB; ctrl.ext = EXT_SIGN; end
                    OPC_ANDI: begin ctrl.alu_op = ALU_AND; ctrl.ext = EXT_ZERO; end
                    default:  begin ctrl.alu_op = ALU_OR;  ctrl.ext = EXT_ZERO; end
                endcase
            end
            OPC_STB: begin
                ctrl.alu_op      = ALU_ADD;
                ctrl.ext         = EXT_SIGN;
                ctrl.alu_src_imm = 1'b1;
                ctrl.mem_wr      = 1'b1;
            end
            OPC_LDB: begin
                ctrl.alu_op      = ALU_ADD;
                ctrl.ext         = EXT_SIGN;
                ctrl.alu_src_imm = 1'b1;
                ctrl.mem_rd      = 1'b1;
                ctrl.mem_to_reg  = 1'b1;
                ctrl.wsel        = WSEL_RT;
            end
            OPC_BEQ: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.ext    = EXT_SIGN;
                ctrl.br_eq  = 1'b1;
            end
            OPC_BNE: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.ext    = EXT_SIGN;
                ctrl.br_ne  = 1'b1;
            end
            OPC_JMP: ctrl.jump = 1'b1;
            OPC_JAL: begin
                ctrl.jump = 1'b1;
                ctrl.link = 1'b1;
                ctrl.wsel = WSEL_LINK;
            end
            default: ctrl.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/cdec_immext.sv
module cdec_immext
    import cdec_pkg::*;
#(
    parameter int IN_W  = IMM_W,
    parameter int OUT_W = INSTR_W
) (
    input  logic [IN_W-1:0]  imm,
    input  ext_kind_e        kind,
    output logic [OUT_W-1:0] imm_ext
);

    localparam int PAD_W = OUT_W - IN_W;

    logic [PAD_W-1:0] pad;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                case (kind)
                    EXT_SIGN: pad = {PAD_W{imm[IN_W-1]}};
                    default:  pad = '0;
                endcase
            end
        end
    endgenerate

    always_comb begin
        case (kind)
            EXT_SIGN, EXT_ZERO: imm_ext = {pad, imm};
            default:            imm_ext = '0;
        endcase
    end

endmodule

// File: rtl/cdec_wsel.sv
module cdec_wsel
    import cdec_pkg::*;
#(
    parameter int                IDX_W    = REG_W,
    parameter logic [IDX_W-1:0]  LINK_IDX = LINK_REG
) (
    input  wsel_e             wsel,
    input  logic [IDX_W-1:0]  rd,
    input  logic [IDX_W-1:0]  rt,
    output logic              we,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        we  = 1'b1;
        idx = '0;
        case (wsel)
            WSEL_RD:   idx = rd;
            WSEL_RT:   idx = rt;
            WSEL_LINK: idx = LINK_IDX;
            default:   we  = 1'b0;
        endcase
    end

endmodule

// File: rtl/cdec_top.sv
module cdec_top
    import cdec_pkg::*;
(
    input  logic [15:0] instr,
    output logic [2:0]  rs_idx,
    output logic [2:0]  rt_idx,
    output logic [2:0]  rd_idx,
    output logic [15:0] imm_ext,
    output logic [6:0]  jmp_field,
    output logic [2:0]  alu_op,
    output logic        reg_we,
    output logic [2:0]  wr_idx,
    output logic        alu_src_imm,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        mem_to_reg,
    output logic        br_eq,
    output logic        br_ne,
    output logic        jump,
    output logic        jump_reg,
    output logic        link,
    output logic        is_mult,
    output logic        illegal
);

    fields_t fld;
    ctrl_t   ctrl;

    assign fld = split_word(instr);

    cdec_ctrl u_ctrl (
        .opc   (fld.opc),
        .funct (fld.funct),
        .ctrl  (ctrl)
    );

    cdec_immext #(
        .IN_W  (IMM_W),
        .OUT_W (INSTR_W)
    ) u_immext (
        .imm     (fld.imm),
        .kind    (ctrl.ext),
        .imm_ext (imm_ext)
    );

    cdec_wsel #(
        .IDX_W    (REG_W),
        .LINK_IDX (LINK_REG)
    ) u_wsel (
        .wsel (ctrl.wsel),
        .rd   (fld.rd),
        .rt   (fld.rt),
        .we   (reg_we),
        .idx  (wr_idx)
    );

    assign rs_idx      = fld.rs;
    assign rt_idx      = fld.rt;
    assign rd_idx      = fld.rd;
    assign jmp_field   = fld.jaddr;
    assign alu_op      = ctrl.alu_op;
    assign alu_src_imm = ctrl.alu_src_imm;
    assign mem_rd      = ctrl.mem_rd;
    assign mem_wr      = ctrl.mem_wr;
    assign mem_to_reg  = ctrl.mem_to_reg;
    assign br_eq       = ctrl.br_eq;
    assign br_ne       = ctrl.br_ne;
    assign jump        = ctrl.jump;
    assign jump_reg    = ctrl.jump_reg;
    assign link        = ctrl.link;
    assign is_mult     = ctrl.is_mult;
    assign illegal     = ctrl.illegal;

endmodule

// File: rtl/cdec_checker.sv
module cdec_checker (
    input logic [15:0] instr,
    input logic [2:0]  alu_op,
    input logic [15:0] imm_ext,
    input logic        reg_we,
    input logic [2:0]  wr_idx,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        mem_to_reg,
    input logic        br_eq,
    input logic        br_ne,
    input logic        jump,
    input logic        jump_reg,
    input logic        link,
    input logic        is_mult,
    input logic        illegal
);

    logic [3:0] opc;
    assign opc = instr[15:12];

    always_comb begin
        if (!$isunknown(instr)) begin
            a_r12_illegal_quiet: assert (!illegal || (!reg_we && !mem_wr && !mem_rd))
                else $error("illegal word produced a write or read");
            a_r11_link_to_r7: assert (!link || (reg_we && wr_idx == 3'd7 && jump))
                else $error("link without write to register 7");
            a_r13_idle_index: assert (reg_we || wr_idx == 3'd0)
                else $error("write index nonzero while not writing");
            a_r10_flow_onehot: assert ($onehot0({br_eq, br_ne, jump, jump_reg}))
                else $error("more than one PC control active");
            a_r9_store_no_wb: assert (!mem_wr || (!reg_we && !mem_rd))
                else $error("store also writes back or reads");
            a_r8_load_path: assert (!mem_to_reg || (mem_rd && reg_we))
                else $error("memory write-back without load");
            a_r3_mult_op: assert (!is_mult || (alu_op == 3'd4 && reg_we))
                else $error("multiply flag without multiply op");
            a_r7_zero_ext: assert (!(opc == 4'h4 || opc == 4'h5) ||
                                   imm_ext == {10'd0, instr[5:0]})
                else $error("logic immediate not zero-extended");
            a_r6_sign_ext: assert (!(opc == 4'h2 || opc == 4'h3 || opc == 4'h6 ||
                                     opc == 4'h7 || opc == 4'h8 || opc == 4'h9) ||
                                   ($signed(imm_ext) == 16'($signed(instr[5:0]))))
                else $error("arithmetic immediate not sign-extended");
        end
    end

endmodule

bind cdec_top cdec_checker u_chk (
    .instr      (instr),
    .alu_op     (alu_op),
    .imm_ext    (imm_ext),
    .reg_we     (reg_we),
    .wr_idx     (wr_idx),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_to_reg (mem_to_reg),
    .br_eq      (br_eq),
    .br_ne      (br_ne),
    .jump       (jump),
    .jump_reg   (jump_reg),
    .link       (link),
    .is_mult    (is_mult),
    .illegal    (illegal)
);

// File: tb/cdec_top_tb.sv
module cdec_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [2:0]  rs_idx, rt_idx, rd_idx, alu_op, wr_idx;
    logic [15:0] imm_ext;
    logic [6:0]  jmp_field;
    logic reg_we, alu_src_imm, mem_rd, mem_wr, mem_to_reg;
    logic br_eq, br_ne, jump, jump_reg, link, is_mult, illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdec_top u_dut (
        .instr(instr), .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx),
        .imm_ext(imm_ext), .jmp_field(jmp_field), .alu_op(alu_op),
        .reg_we(reg_we), .wr_idx(wr_idx), .alu_src_imm(alu_src_imm),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_to_reg(mem_to_reg),
        .br_eq(br_eq), .br_ne(br_ne), .jump(jump), .jump_reg(jump_reg),
        .link(link), .is_mult(is_mult), .illegal(illegal)
    );

    typedef struct packed {
        logic [2:0]  alu;
        logic        we;
        logic [2:0]  widx;
        logic        src;
        logic        mrd, mwr, m2r, beq, bne, jmp, jr, lnk, mul, ill;
        logic [15:0] imm;
    } exp_t;

    // behavioural model written from the requirement list
    function automatic exp_t model(input int w);
        exp_t e;
        int op = (w >> 12) & 15;
        int fn = w & 7;
        int rt = (w >> 6) & 7;
        int rd = (w >> 3) & 7;
        int i6 = w & 63;
        int sx = (i6 >= 32) ? (i6 - 64) : i6;
        e = '0;
        if (op == 0) begin
            if (fn == 7)      e.jr = 1'b1;
            else if (fn == 6) e.ill = 1'b1;
            else begin
                e.alu = 3'(fn); e.we = 1'b1; e.widx = 3'(rd); e.mul = (fn == 4);
            end
        end else if (op >= 2 && op <= 5) begin
            e.alu = 3'(op - 2); e.we = 1'b1; e.widx = 3'(rt); e.src = 1'b1;
            e.imm = (op <= 3) ? 16'(sx) : 16'(i6);
        end else if (op == 6) begin
            e.mwr = 1'b1; e.src = 1'b1; e.imm = 16'(sx);
        end else if (op == 7) begin
            e.mrd = 1'b1; e.m2r = 1'b1; e.we = 1'b1; e.widx = 3'(rt);
            e.src = 1'b1; e.imm = 16'(sx);
        end else if (op == 8 || op == 9) begin
            e.alu = 3'd1; e.imm = 16'(sx);
            if (op == 8) e.beq = 1'b1; else e.bne = 1'b1;
        end else if (op == 14) begin
            e.jmp = 1'b1;
        end else if (op == 15) begin
            e.jmp = 1'b1; e.lnk = 1'b1; e.we = 1'b1; e.widx = 3'd7;
        end else begin
            e.ill = 1'b1;
        end
        return e;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s instr=%04h actual=%0h expected=%0h", req, what, instr, act, exp);
        end
    endtask

    task automatic compare_all();
        exp_t e = model(int'(instr));
        int op = int'(instr[15:12]);
        string immreq = (op == 4 || op == 5) ? "R7" : "R6";
        if (!(op >= 2 && op <= 9)) immreq = "R7";
        chk("R1", "rs_idx", int'(rs_idx), int'(instr[11:9]));
        chk("R1", "rt_idx", int'(rt_idx), int'(instr[8:6]));
        chk("R1", "rd_idx", int'(rd_idx), int'(instr[5:3]));
        chk("R1", "jmp_field", int'(jmp_field), int'(instr[6:0]));
        chk(immreq, "imm_ext", int'(imm_ext), int'(e.imm));
        chk("R2", "alu_op", int'(alu_op), int'(e.alu));
        chk("R5", "alu_src_imm", int'(alu_src_imm), int'(e.src));
        chk("R12", "reg_we", int'(reg_we), int'(e.we));
        chk("R13", "wr_idx", int'(wr_idx), int'(e.widx));
        chk("R8", "mem_rd", int'(mem_rd), int'(e.mrd));
        chk("R8", "mem_to_reg", int'(mem_to_reg), int'(e.m2r));
        chk("R9", "mem_wr", int'(mem_wr), int'(e.mwr));
        chk("R10", "br_eq", int'(br_eq), int'(e.beq));
        chk("R10", "br_ne", int'(br_ne), int'(e.bne));
        chk("R11", "jump", int'(jump), int'(e.jmp));
        chk("R11", "link", int'(link), int'(e.lnk));
        chk("R4", "jump_reg", int'(jump_reg), int'(e.jr));
        chk("R3", "is_mult", int'(is_mult), int'(e.mul));
        chk("R12", "illegal", int'(illegal), int'(e.ill));
    endtask

    task automatic apply(input logic [15:0] w);
        @(posedge clk);
        instr <= w;
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // initial state: word 0 decodes as add r0 into r0
        @(negedge clk);
        compare_all();
        chk("R2", "initial reg_we", int'(reg_we), 1);

        // R6: most negative and most positive 6-bit immediate on add-immediate
        apply(16'h2060);
        chk("R6", "imm -32", int'(imm_ext), 16'hFFE0);
        apply(16'h205F);
        chk("R6", "imm +31", int'(imm_ext), 16'h001F);
        // R7: all-ones immediate on or-immediate stays positive
        apply(16'h507F);
        chk("R7", "ori imm 3F", int'(imm_ext), 16'h003F);
        // R11: jump-and-link targets register 7
        apply(16'hF07F);
        chk("R11", "jal wr_idx", int'(wr_idx), 7);
        // R3: multiply
        apply(16'h029C);
        chk("R3", "mult flag", int'(is_mult), 1);
        // R4: register jump
        apply(16'h0E07);
        chk("R4", "jr no write", int'(reg_we), 0);
        // R12: undefined funct and opcodes
        apply(16'h0FFE);
        chk("R12", "funct 110", int'(illegal), 1);
        apply(16'h1FFF);
        chk("R12", "opcode 0001", int'(illegal), 1);
        apply(16'hDFFF);
        chk("R12", "opcode 1101 no write", int'(reg_we), 0);
        // R9 / R8 / R10
        apply(16'h6FFF);
        chk("R9", "store", int'(mem_wr), 1);
        apply(16'h7FFF);
        chk("R8", "load", int'(mem_to_reg), 1);
        apply(16'h9A20);
        chk("R10", "bne", int'(br_ne), 1);

        // exhaustive sweep of every word against the model
        for (int w = 0; w < 65536; w++) begin
            apply(16'(w));
        end

        finish_run();
    end

endmodule